// File: doc/BRIEF.md
# Master/Slave Serial Peripheral Engine

This block moves one character of programmable length across a four-wire serial link, shifting out and shifting in at the same time. As master it makes the serial clock and a low-active select from the system clock, using a 7-bit divider code. As slave it follows a serial clock and select that come from outside. These are first passed through a synchronizer. Static configuration pins choose the mode, the clock idle level, the clock phase, the character length, the divider code and whether the data output is driven.

Words to send arrive on a valid/ready stream. A word is taken on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low while a character is on the wire, or while a slave word waits to be sent, so the word in flight cannot change. Received characters appear on a second valid/ready stream. `rx_valid` stays high until `rx_ready` takes the word. The receive side never stalls the link. A character that finishes while the previous word is still unread replaces it and raises a sticky overrun flag. Two interrupt outputs give the same status that software could poll.

Top module: `spi_engine`

## Requirements
- R1: In master mode with divider code N, each serial bit lasts P = max(N,3)+1 system clocks. The first half of the bit lasts floor(P/2) clocks and the second half lasts the rest, so codes 0 to 2 all give P = 4.
- R2: When idle, `sclk_o` equals `cfg_cpol`. With `cfg_cpha`=0, each bit is presented before the first clock edge of that bit and sampled on that edge. With `cfg_cpha`=1, each bit is presented at the first clock edge of that bit and sampled on the second edge.
- R3: A character has `cfg_len`+1 bits. They are sent MSB-first starting at `tx_data[15]`. The received bits are right-justified in `rx_data`, and the bits above them read zero.
- R4: In master mode, `ste_o` is low and `tx_ready` is low for exactly len·P cycles. These start on the cycle after the word is accepted. A change of `tx_data` during that time has no effect on the character.
- R5: With `cfg_tx_en`=0, `mosi_o` and `miso_o` stay 0 while reception goes on normally.
- R6: `rx_valid` rises on the cycle after `irq_tx` pulses and holds with stable data until a cycle with `rx_ready` high. `irq_rx` equals `rx_valid`.
- R7: A character that completes while `rx_valid` is high and `rx_ready` is low replaces `rx_data` and sets `rx_ovr`. A completion on the same cycle as a read sets no overrun. A read clears `rx_ovr`.
- R8: `irq_tx` pulses for one cycle when a character ends. In master mode this is the cycle on which `ste_o` returns high.
- R9: In slave mode, while `ste_i` is low, the block samples `mosi_i` and drives `miso_o` on the edges that R2 selects, taken from `sclk_i`. The word to send comes from the transmit stream, loaded beforehand. `miso_o` is 0 while `ste_i` is high.
- R10: After reset, `ste_o`=1, `sclk_o`=`cfg_cpol`, `tx_ready`=1, and `mosi_o`, `rx_valid`, `rx_ovr`, `irq_tx` and `irq_rx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master | input | 1 | 1 master, 0 slave |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0 sample on first edge, 1 on second |
| cfg_tx_en | input | 1 | Drive the data output |
| cfg_len | input | 4 | Character length minus one |
| cfg_baud | input | 7 | Divider code N |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be taken |
| tx_data | input | 16 | Left-justified transmit word |
| rx_valid | output | 1 | Received word held |
| rx_ready | input | 1 | Consumer takes received word |
| rx_data | output | 16 | Right-justified received word |
| rx_ovr | output | 1 | Sticky receive overrun |
| irq_tx | output | 1 | Character-done pulse |
| irq_rx | output | 1 | Receive word pending |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_i | input | 1 | Master data in |
| ste_o | output | 1 | Low-active select out (master) |
| ste_i | input | 1 | Low-active select in (slave) |

## Verification
The case that matters is a character finishing on the same cycle that the consumer reads the previous word. On that cycle the read clears the overrun flag, the new word loads, and `rx_valid` has to stay high without an overrun. The bench provokes this by holding `rx_ready` low over one character. It then raises `rx_ready` only on the cycle where its model expects the next word to land. The bench also runs two unread characters in a row, which sets the flag. A behavioural model predicts `rx_valid`, `rx_data` and `rx_ovr` on every clock and is the reference for judging them.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned MIN_DIV_CODE = 3;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic txen;
  } spi_shape_t;
endpackage

// File: rtl/spi_eng_master.sv
module spi_eng_master
  import spi_eng_pkg::*;
#(
  parameter int W  = 16,
  parameter int LW = 4,
  parameter int BW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  word,
  input  spi_shape_t    shape,
  input  logic [LW-1:0] len_m1,
  input  logic [BW-1:0] baud,
  input  logic          sin,
  output logic          busy,
  output logic          done,
  output logic          sclk,
  output logic          sout,
  output logic          ste_n,
  output logic [W-1:0]  rxw
);
  logic [BW:0]   per;
  logic [BW-1:0] h1, h2, hcur, cnt;
  logic          phase;
  logic [LW-1:0] bitc;
  logic [W-1:0]  sh;

  // bit period and its two halves; modulo arithmetic keeps h2 right at P=2^BW
  assign per  = (baud < BW'(MIN_DIV_CODE)) ? (BW+1)'(MIN_DIV_CODE + 1)
                                            : {1'b0, baud} + 1'b1;
  assign h1   = per[BW:1];
  assign h2   = per[BW-1:0] - h1;
  assign hcur = phase ? h2 : h1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= 1'b0;
      cnt   <= '0;
      bitc  <= '0;
      sh    <= '0;
      rxw   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          phase <= 1'b0;
          cnt   <= '0;
          bitc  <= '0;
          sh    <= word;
          rxw   <= '0;
        end
      end else if (cnt == hcur - 1'b1) begin
        cnt <= '0;
        if (!phase) begin
          phase <= 1'b1;
          rxw   <= (rxw << 1) | W'(sin);
        end else begin
          phase <= 1'b0;
          if (bitc == len_m1) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitc <= bitc + 1'b1;
            sh   <= sh << 1;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign sclk  = busy ? (shape.cpol ^ shape.cpha ^ phase) : shape.cpol;
  assign sout  = busy & shape.txen & sh[W-1];
  assign ste_n = ~busy;
endmodule

// File: rtl/spi_eng_slave.sv
module spi_eng_slave
  import spi_eng_pkg::*;
#(
  parameter int W    = 16,
  parameter int LW   = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [W-1:0]  word,
  input  spi_shape_t    shape,
  input  logic [LW-1:0] len_m1,
  input  logic          sclk_in,
  input  logic          sdi,
  input  logic          sel_n,
  output logic          busy,
  output logic          done,
  output logic          sout,
  output logic [W-1:0]  rxw
);
  logic [2:0]    stg [SYNC];
  logic          sck_s, sdi_s, sel_s, sck_prev;
  logic          act, chg, lead, trail, samp, shft, full;
  logic [LW-1:0] cntb;
  logic [W-1:0]  sh, rsh;

  // synchronizer chain for {clock, data, select}; select resets inactive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= 3'b001;
    else        stg[0] <= {sclk_in, sdi, sel_n};
  end
  for (genvar k = 1; k < SYNC; k++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= 3'b001;
      else        stg[k] <= stg[k-1];
    end
  end
  assign {sck_s, sdi_s, sel_s} = stg[SYNC-1];

  assign act   = en & ~sel_s;
  assign chg   = sck_s ^ sck_prev;
  assign lead  = act & chg & (sck_s != shape.cpol);
  assign trail = act & chg & (sck_s == shape.cpol);
  assign samp  = shape.cpha ? trail : lead;
  assign shft  = shape.cpha ? lead : trail;
  assign busy  = full | (cntb != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      done     <= 1'b0;
      full     <= 1'b0;
      cntb     <= '0;
      sh       <= '0;
      rsh      <= '0;
      rxw      <= '0;
    end else begin
      done     <= 1'b0;
      sck_prev <= sck_s;
      if (load && !busy) begin
        sh   <= word;
        full <= 1'b1;
      end
      if (!act) begin
        cntb <= '0;
        rsh  <= '0;
      end else begin
        if (samp) begin
          if (cntb == len_m1) begin
            rxw  <= (rsh << 1) | W'(sdi_s);
            rsh  <= '0;
            cntb <= '0;
            done <= 1'b1;
            full <= 1'b0;
            sh   <= '0;
          end else begin
            rsh  <= (rsh << 1) | W'(sdi_s);
            cntb <= cntb + 1'b1;
          end
        end
        // the first shift edge of a character has no sample before it
        if (shft && cntb != '0) sh <= sh << 1;
      end
    end
  end

  assign sout = act & shape.txen & sh[W-1];
endmodule

// File: rtl/spi_eng_rxhold.sv
module spi_eng_rxhold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] word,
  input  logic         rdy,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      ovr   <= 1'b0;
    end else begin
      if (valid && rdy) begin
        valid <= 1'b0;
        ovr   <= 1'b0;
      end
      if (push) begin
        data  <= word;
        valid <= 1'b1;
        if (valid && !rdy) ovr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_engine.sv
module spi_engine
  import spi_eng_pkg::*;
#(
  parameter int W    = 16,
  parameter int BW   = 7,
  parameter int SYNC = 2,
  localparam int LW  = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          cfg_tx_en,
  input  logic [LW-1:0] cfg_len,
  input  logic [BW-1:0] cfg_baud,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [W-1:0]  tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [W-1:0]  rx_data,
  output logic          rx_ovr,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          sclk_o,
  input  logic          sclk_i,
  output logic          mosi_o,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          miso_i,
  output logic          ste_o,
  input  logic          ste_i
);
  spi_shape_t   shape;
  logic         m_busy, m_done, m_sout;
  logic         s_busy, s_done, s_sout;
  logic [W-1:0] m_rxw, s_rxw;

  assign shape = '{cpol: cfg_cpol, cpha: cfg_cpha, txen: cfg_tx_en};

  spi_eng_master #(.W(W), .LW(LW), .BW(BW)) u_mst (
    .clk(clk), .rst_n(rst_n),
    .start(cfg_master & tx_valid & ~m_busy), .word(tx_data),
    .shape(shape), .len_m1(cfg_len), .baud(cfg_baud), .sin(miso_i),
    .busy(m_busy), .done(m_done), .sclk(sclk_o), .sout(m_sout),
    .ste_n(ste_o), .rxw(m_rxw)
  );

  spi_eng_slave #(.W(W), .LW(LW), .SYNC(SYNC)) u_slv (
    .clk(clk), .rst_n(rst_n), .en(~cfg_master),
    .load(~cfg_master & tx_valid), .word(tx_data),
    .shape(shape), .len_m1(cfg_len),
    .sclk_in(sclk_i), .sdi(mosi_i), .sel_n(ste_i),
    .busy(s_busy), .done(s_done), .sout(s_sout), .rxw(s_rxw)
  );

  spi_eng_rxhold #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .push(m_done | s_done),
    .word(m_done ? m_rxw : s_rxw), .rdy(rx_ready),
    .valid(rx_valid), .data(rx_data), .ovr(rx_ovr)
  );

  assign tx_ready = cfg_master ? ~m_busy : ~s_busy;
  assign mosi_o   = cfg_master & m_sout;
  assign miso_o   = ~cfg_master & s_sout;
  assign irq_tx   = m_done | s_done;
  assign irq_rx   = rx_valid;
endmodule

// File: rtl/spi_engine_chk.sv
module spi_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_cpol,
  input logic cfg_cpha,
  input logic cfg_tx_en,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic rx_ovr,
  input logic irq_tx,
  input logic irq_rx,
  input logic sclk_o,
  input logic mosi_o,
  input logic miso_o,
  input logic ste_o
);
  assert_sel_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && !ste_o) |-> !tx_ready);

  assert_idle_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && ste_o) |-> (sclk_o == cfg_cpol));

  assert_min_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $stable({cfg_cpol, cfg_cpha, cfg_master}) && (sclk_o != $past(sclk_o)))
      |=> (sclk_o == $past(sclk_o)));

  assert_tx_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx_en |-> (!mosi_o && !miso_o));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |=> !irq_tx);

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  assert_rx_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx == rx_valid);

  assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_valid && !rx_ready));
endmodule

bind spi_engine spi_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
  .cfg_cpha(cfg_cpha), .cfg_tx_en(cfg_tx_en), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ovr(rx_ovr),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .sclk_o(sclk_o), .mosi_o(mosi_o),
  .miso_o(miso_o), .ste_o(ste_o)
);

// File: tb/sim_spi_engine.sv
module sim_spi_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_tx_en = 1'b1;
  logic [3:0] cfg_len = 4'd15;
  logic [6:0] cfg_baud = 7'd0;
  logic tx_valid = 1'b0, rx_ready;
  logic [15:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_ovr, irq_tx, irq_rx;
  logic [15:0] rx_data;
  logic sclk_o, mosi_o, miso_o, ste_o;
  logic sclk_i = 1'b0, mosi_i = 1'b0, ste_i = 1'b1, miso_i;

  always #2 clk = ~clk;

  spi_engine u0 (.*);

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural master-mode model
  bit mchk = 1'b0;
  bit mbusy, irq_e, rxv_e, ovr_e, old_v, rdy_man = 1'b0;
  int mj, mL, mP, rpol = 0;
  logic [15:0] mword, msw, pend, rxd_e, sw_next = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; irq_e = 0; rxv_e = 0; ovr_e = 0; rxd_e = '0;
      miso_i <= 1'b0;
      rx_ready <= 1'b0;
    end else begin
      if (mchk) begin
        old_v = rxv_e;
        if (old_v && rx_ready) begin rxv_e = 0; ovr_e = 0; end
        if (irq_e) begin
          rxd_e = pend;
          if (old_v && !rx_ready) ovr_e = 1;
          rxv_e = 1;
        end
        irq_e = 0;
        if (mbusy) begin
          if (mj + 1 == mL * mP) begin
            mbusy = 0; irq_e = 1;
            pend = msw & 16'((1 << mL) - 1);
          end else mj++;
        end else if (tx_valid) begin
          mbusy = 1; mj = 0; mword = tx_data; msw = sw_next;
          mL = int'(cfg_len) + 1;
          mP = (cfg_baud < 3) ? 4 : int'(cfg_baud) + 1;
        end
        miso_i <= mbusy ? msw[mL - 1 - mj / mP] : 1'b0;
      end
      rx_ready <= (rpol == 0) || (rpol == 2 && irq_e) || (rpol == 3 && rdy_man);
    end
  end

  always @(negedge clk) begin
    if (rst_n && mchk) begin
      chk("R1/R2 sclk_o", sclk_o,
          mbusy ? (cfg_cpol ^ cfg_cpha ^ ((mj % mP) >= mP / 2)) : cfg_cpol);
      chk("R3/R5 mosi_o", mosi_o, (mbusy && cfg_tx_en) ? mword[15 - mj / mP] : 1'b0);
      chk("R4 ste_o", ste_o, !mbusy);
      chk("R4 tx_ready", tx_ready, !mbusy);
      chk("R8 irq_tx", irq_tx, irq_e);
      chk("R6 rx_valid", rx_valid, rxv_e);
      chk("R6 irq_rx", irq_rx, rxv_e);
      chk("R7 rx_ovr", rx_ovr, ovr_e);
      if (rxv_e) chk("R3 rx_data", rx_data, rxd_e);
    end
  end

  task automatic wt(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic mrun(bit pol, bit pha, int len, int baud, bit ten,
                      logic [15:0] w, logic [15:0] sw, int rp, bit b2b);
    cfg_cpol = pol; cfg_cpha = pha; cfg_len = 4'(len - 1);
    cfg_baud = 7'(baud); cfg_tx_en = ten; rpol = rp; sw_next = sw;
    wt(2);
    tx_data = w; tx_valid = 1'b1;
    do wt(1); while (!(mbusy && mj == 0));
    if (b2b) begin
      tx_data = ~w;
      wt(1);
      do wt(1); while (!(mbusy && mj == 0));
    end
    tx_valid = 1'b0;
    tx_data = w ^ 16'h5A5A;  // R4: change during the character
    do wt(1); while (mbusy);
    wt(3);
  endtask

  task automatic srun(bit pol, bit pha, int len, logic [15:0] tw, logic [15:0] rw);
    cfg_cpol = pol; cfg_cpha = pha; cfg_len = 4'(len - 1); cfg_tx_en = 1'b1;
    sclk_i = pol; ste_i = 1'b1;
    wt(6);
    chk("R9 slave tx_ready idle", tx_ready, 1);
    tx_data = tw; tx_valid = 1'b1;
    wt(1);
    tx_valid = 1'b0;
    wt(4);
    chk("R9 miso_o quiet", miso_o, 0);
    ste_i = 1'b0;
    wt(8);
    for (int b = 0; b < len; b++) begin
      if (!pha) begin
        mosi_i = rw[len - 1 - b];
        wt(8);
        chk("R9 slave bit out", miso_o, tw[15 - b]);
        sclk_i = ~pol; wt(8);
        sclk_i = pol;
      end else begin
        sclk_i = ~pol;
        mosi_i = rw[len - 1 - b];
        wt(8);
        chk("R9 slave bit out", miso_o, tw[15 - b]);
        sclk_i = pol; wt(8);
      end
    end
    wt(8);
    ste_i = 1'b1;
    wt(6);
    chk("R9 slave rx_valid", rx_valid, 1);
    chk("R9 slave rx_data", rx_data, rw & 16'((1 << len) - 1));
    chk("R9 slave tx_ready after", tx_ready, 1);
    rdy_man = 1'b1; wt(2); rdy_man = 1'b0; wt(1);
    chk("R6 slave read clears", rx_valid, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    wt(5);
    #1;
    chk("R10 ste_o", ste_o, 1);
    chk("R10 sclk_o", sclk_o, 0);
    chk("R10 mosi_o", mosi_o, 0);
    chk("R10 tx_ready", tx_ready, 1);
    chk("R10 rx_valid", rx_valid, 0);
    chk("R10 rx_ovr", rx_ovr, 0);
    chk("R10 irq", {irq_tx, irq_rx}, 0);
    rst_n = 1'b1;
    wt(2);
    mchk = 1'b1;
    mrun(0, 0, 16, 0, 1, 16'hA5C3, 16'h3C5A, 0, 0);   // R3 full length, R1 code 0
    mrun(0, 1, 8, 4, 1, 16'hB700, 16'h00C9, 0, 0);    // R2 phase 1, R1 odd period
    mrun(1, 0, 1, 2, 1, 16'h8000, 16'h0001, 0, 0);    // R3 single bit
    mrun(1, 1, 12, 9, 1, 16'h9E70, 16'h0A5B, 0, 0);   // R2 idle high
    mrun(0, 0, 7, 5, 0, 16'hFE00, 16'h0055, 0, 0);    // R5 transmit off
    mrun(1, 0, 4, 127, 1, 16'hD000, 16'h0006, 0, 0);  // R1 slowest rate
    mrun(0, 1, 5, 3, 1, 16'h6800, 16'h0013, 0, 1);    // R4 back-to-back
    mrun(0, 0, 6, 6, 1, 16'hC400, 16'h002D, 1, 0);    // R6 held unread
    mrun(0, 0, 6, 6, 1, 16'h7C00, 16'h0012, 1, 0);    // R7 overrun set
    mrun(1, 1, 9, 3, 1, 16'h5580, 16'h01A3, 2, 0);    // R7 read meets completion
    mrun(0, 0, 3, 4, 1, 16'hA000, 16'h0005, 0, 0);    // R7 drain and clear
    mchk = 1'b0;
    rpol = 3;
    cfg_master = 1'b0;
    srun(0, 0, 8, 16'hB600, 16'h00C5);                // R9 slave phase 0
    srun(1, 1, 16, 16'h1E2D, 16'hE1D2);               // R9 slave phase 1
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule